// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks, oscillator stages, the core regulator and data retention are powered in a small 16-bit microcontroller. It holds a 3-bit operating mode. Software running on the CPU writes the mode. The block turns the mode into ten registered enable outputs. Each lower-power mode switches off a further set of resources, so the modes form a graded ladder from fully running to fully off.

An interrupt taken while the device sleeps wakes it to the running mode and stores the sleep mode in a one-entry save register. The return-from-handler strobe then puts the sleep mode back. The deepest mode drops the regulator and retention, so nothing can be saved or restored from it. Ordinary interrupts do not wake it. Only a digital I/O wake event or a reset leaves it, and a wake event also raises a one-cycle reset request.

Top module: `pwrModeCtl`

## Requirements
- R1: After reset, curMode is 0 (running), all ten enables are 1, and resetReq is 0.
- R2: A mode write takes effect at the next clock edge only while curMode is 0. Write value 7 is stored and reported as 0. A write while curMode is 1 to 6 has no effect.
- R3: The mode encoding is as follows:
  - 0: running
  - 1 to 5: sleep levels 0 to 4
  - 6: off

  The enables follow curMode one clock later:
  - cpuRun and mclkEn are 1 only in mode 0.
  - fllEn is 1 in modes 0 and 1.
  - smclkEn and dcoEn are 1 in modes 0 to 2.
  - dcGenEn is 1 in modes 0 to 3.
  - aclkEn and xtalEn are 1 in modes 0 to 4.
  - regulatorEn and retainEn are 1 in modes 0 to 5.
- R4: irqTake in modes 1 to 5 saves the mode and sets curMode to 0 at the next edge. irqTake in mode 0 outside a handler saves 0 and enters the handler.
- R5: retiStrobe in mode 0 inside a handler restores the saved mode and ends the handler. retiStrobe outside a handler, or while curMode is not 0, has no effect.
- R6: In mode 6, irqTake, retiStrobe and writes have no effect. ioWake sets curMode to 0 and pulses resetReq high for exactly one cycle at the same edge. ioWake in any other mode has no effect.
- R7: If several requests arrive in the same cycle, the priority is: accepted irqTake first, then accepted retiStrobe, then the mode write.
- R8: irqTake while in mode 0 inside a handler is ignored, and the saved mode is kept.
- R9: regulatorEn and retainEn are both 0 only when the previous mode was 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Software mode-write strobe |
| modeWrData | input | 3 | Mode value to write |
| irqTake | input | 1 | Interrupt entry strobe |
| retiStrobe | input | 1 | Return-from-interrupt strobe |
| ioWake | input | 1 | Digital I/O wake event |
| curMode | output | 3 | Current mode |
| cpuRun | output | 1 | CPU run enable |
| mclkEn | output | 1 | CPU clock enable |
| smclkEn | output | 1 | Subsystem clock enable |
| aclkEn | output | 1 | Auxiliary clock enable |
| dcoEn | output | 1 | Digitally controlled oscillator enable |
| dcGenEn | output | 1 | Oscillator DC generator enable |
| fllEn | output | 1 | Frequency-locked loop control enable |
| xtalEn | output | 1 | Crystal oscillator enable |
| regulatorEn | output | 1 | Core regulator enable |
| retainEn | output | 1 | Data retention enable |
| resetReq | output | 1 | One-cycle reset request on leaving off mode |

## Verification
The bench starts from every mode value, including the reserved 7, and checks all ten enables against per-mode thresholds.
- A wrong ladder entry would switch a clock off one level too early or too late.
- A design that accepts writes while asleep would change mode with the CPU stopped.

It also checks that interrupts and returns are ignored in mode 6, and that ioWake raises a reset request there but nowhere else. A design that stored the saved mode too freely would fail two tests:
- A second interrupt inside the handler would overwrite the saved mode, so the return would land in the running mode.
- A return outside a handler would jump to a stale mode.

Same-cycle collisions check the priority order.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int MODE_W = 3;
  localparam int GATE_N = 10;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN  = 3'd0,
    MODE_SL0  = 3'd1,
    MODE_SL1  = 3'd2,
    MODE_SL2  = 3'd3,
    MODE_SL3  = 3'd4,
    MODE_SL4  = 3'd5,
    MODE_OFF  = 3'd6,
    MODE_RSVD = 3'd7
  } pwrMode_e;

  typedef struct packed {
    logic takeIrq;
    logic restore;
    logic swWrite;
    logic offWake;
  } modeStrobe_t;

  typedef struct packed {
    logic cpuRun;
    logic mclk;
    logic smclk;
    logic aclk;
    logic dco;
    logic dcGen;
    logic fll;
    logic xtal;
    logic regulator;
    logic retain;
  } gateVec_t;

  localparam gateVec_t GATES_ALL_ON = '1;

endpackage

// File: rtl/pwrGateDecode.sv
module pwrGateDecode
  import pwr_mode_pkg::*;
(
  input  pwrMode_e mode,
  output gateVec_t gates
);

  always_comb begin
    gates = GATES_ALL_ON;
    unique case (mode)
      MODE_SL0: begin
        gates.cpuRun = 1'b0;
        gates.mclk   = 1'b0;
      end
      MODE_SL1: begin
        gates.cpuRun = 1'b0;
        gates.mclk   = 1'b0;
        gates.fll    = 1'b0;
      end
      MODE_SL2: begin
        gates.cpuRun = 1'b0;
        gates.mclk   = 1'b0;
        gates.smclk  = 1'b0;
        gates.fll    = 1'b0;
        gates.dco    = 1'b0;
      end
      MODE_SL3: begin
        gates.cpuRun = 1'b0;
        gates.mclk   = 1'b0;
        gates.smclk  = 1'b0;
        gates.fll    = 1'b0;
        gates.dco    = 1'b0;
        gates.dcGen  = 1'b0;
      end
      MODE_SL4: begin
        gates           = '0;
        gates.regulator = 1'b1;
        gates.retain    = 1'b1;
      end
      MODE_OFF: begin
        gates = '0;
      end
      default: gates = GATES_ALL_ON;
    endcase
  end

endmodule

// File: rtl/pwrModeControl.sv
module pwrModeControl
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic        irqTake,
  input  logic        retiStrobe,
  input  logic        ioWake,
  input  pwrMode_e    modeNow,
  output modeStrobe_t strobe
);

  logic inHandler;
  logic isRun;
  logic isOff;
  logic takeOk;
  logic retOk;

  assign isRun  = (modeNow == MODE_RUN);
  assign isOff  = (modeNow == MODE_OFF);
  assign takeOk = irqTake && !isOff && !(isRun && inHandler);
  assign retOk  = !takeOk && retiStrobe && isRun && inHandler;

  always_comb begin
    strobe         = '0;
    strobe.takeIrq = takeOk;
    strobe.restore = retOk;
    strobe.swWrite = !takeOk && !retOk && modeWrEn && isRun;
    strobe.offWake = isOff && ioWake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inHandler <= 1'b0;
    end else if (strobe.offWake || strobe.restore) begin
      inHandler <= 1'b0;
    end else if (strobe.takeIrq) begin
      inHandler <= 1'b1;
    end
  end

endmodule

// File: rtl/pwrModeDatapath.sv
module pwrModeDatapath
  import pwr_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  modeStrobe_t        strobe,
  input  logic [MODE_W-1:0]  wrData,
  output pwrMode_e           modeNow,
  output gateVec_t           gatesQ,
  output logic               resetReqQ
);

  pwrMode_e modeQ;
  pwrMode_e savedQ;
  pwrMode_e wrMode;
  gateVec_t gatesD;

  assign wrMode  = (wrData == MODE_RSVD) ? MODE_RUN : pwrMode_e'(wrData);
  assign modeNow = modeQ;

  pwrGateDecode u_dec (
    .mode (modeQ),
    .gates(gatesD)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_RUN;
      savedQ <= MODE_RUN;
    end else if (strobe.offWake) begin
      modeQ  <= MODE_RUN;
      savedQ <= MODE_RUN;
    end else if (strobe.takeIrq) begin
      savedQ <= modeQ;
      modeQ  <= MODE_RUN;
    end else if (strobe.restore) begin
      modeQ <= savedQ;
    end else if (strobe.swWrite) begin
      modeQ <= wrMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gatesQ    <= GATES_ALL_ON;
      resetReqQ <= 1'b0;
    end else begin
      gatesQ    <= gatesD;
      resetReqQ <= strobe.offWake;
    end
  end

endmodule

// File: rtl/pwrModeCtl.sv
module pwrModeCtl
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [2:0]  modeWrData,
  input  logic        irqTake,
  input  logic        retiStrobe,
  input  logic        ioWake,
  output logic [2:0]  curMode,
  output logic        cpuRun,
  output logic        mclkEn,
  output logic        smclkEn,
  output logic        aclkEn,
  output logic        dcoEn,
  output logic        dcGenEn,
  output logic        fllEn,
  output logic        xtalEn,
  output logic        regulatorEn,
  output logic        retainEn,
  output logic        resetReq
);

  modeStrobe_t strobe;
  pwrMode_e    modeNow;
  gateVec_t    gates;

  pwrModeControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .modeWrEn  (modeWrEn),
    .irqTake   (irqTake),
    .retiStrobe(retiStrobe),
    .ioWake    (ioWake),
    .modeNow   (modeNow),
    .strobe    (strobe)
  );

  pwrModeDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (modeWrData),
    .modeNow  (modeNow),
    .gatesQ   (gates),
    .resetReqQ(resetReq)
  );

  assign curMode     = modeNow;
  assign cpuRun      = gates.cpuRun;
  assign mclkEn      = gates.mclk;
  assign smclkEn     = gates.smclk;
  assign aclkEn      = gates.aclk;
  assign dcoEn       = gates.dco;
  assign dcGenEn     = gates.dcGen;
  assign fllEn       = gates.fll;
  assign xtalEn      = gates.xtal;
  assign regulatorEn = gates.regulator;
  assign retainEn    = gates.retain;

endmodule

// File: rtl/pwrModeCtl_chk.sv
module pwrModeCtl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeWrEn,
  input logic [2:0] modeWrData,
  input logic       irqTake,
  input logic       retiStrobe,
  input logic       ioWake,
  input logic [2:0] curMode,
  input logic       cpuRun,
  input logic       mclkEn,
  input logic       smclkEn,
  input logic       aclkEn,
  input logic       dcoEn,
  input logic       dcGenEn,
  input logic       fllEn,
  input logic       xtalEn,
  input logic       regulatorEn,
  input logic       retainEn,
  input logic       resetReq
);

  function automatic logic [9:0] ladder(input logic [2:0] m);
    ladder = {m == 3'd0, m == 3'd0, m <= 3'd2, m <= 3'd4, m <= 3'd2,
              m <= 3'd3, m <= 3'd1, m <= 3'd4, m <= 3'd5, m <= 3'd5};
  endfunction

  logic [9:0] enVec;
  logic       sleeping;
  assign enVec = {cpuRun, mclkEn, smclkEn, aclkEn, dcoEn, dcGenEn, fllEn,
                  xtalEn, regulatorEn, retainEn};
  assign sleeping = (curMode >= 3'd1) && (curMode <= 3'd5);

  a_r3_enables_follow_mode: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> enVec == ladder($past(curMode)));

  a_r2_write_ignored_asleep: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && !irqTake) |=> curMode == $past(curMode));

  a_r4_irq_wakes: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && irqTake) |=> curMode == 3'd0);

  a_r6_off_holds: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd6 && !ioWake) |=> curMode == 3'd6);

  a_r6_wake_reset_req: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd6 && ioWake) |=> (resetReq && curMode == 3'd0));

  a_r6_req_only_from_off: assert property (@(posedge clk) disable iff (!rstN)
    !(curMode == 3'd6 && ioWake) |=> !resetReq);

  a_r9_retention_off_only: assert property (@(posedge clk) disable iff (!rstN)
    (!retainEn || !regulatorEn) |-> $past(curMode) == 3'd6);

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    curMode != 3'd7);

endmodule

bind pwrModeCtl pwrModeCtl_chk u_chk (.*);

// File: tb/test_pwrModeCtl.sv
`timescale 1ns/1ps
module test_pwrModeCtl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 1'b0;
  logic [2:0] modeWrData = '0;
  logic irqTake = 1'b0;
  logic retiStrobe = 1'b0;
  logic ioWake = 1'b0;
  logic [2:0] curMode;
  logic cpuRun, mclkEn, smclkEn, aclkEn, dcoEn, dcGenEn, fllEn, xtalEn;
  logic regulatorEn, retainEn, resetReq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int em = 0;
  int es = 0;
  bit ei = 1'b0;

  always #2.5 clk = ~clk;

  pwrModeCtl i_pwrModeCtl (.*);

  function automatic logic [9:0] expEn(input int m);
    expEn = {m == 0, m == 0, m <= 2, m <= 4, m <= 2, m <= 3, m <= 1, m <= 4,
             m <= 5, m <= 5};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    em = 0; es = 0; ei = 1'b0;
  endtask

  task automatic step(input bit wr, input int wd, input bit irq, input bit reti,
                      input bit wake, input string req);
    bit off, tk, rt, wk;
    @(negedge clk);
    modeWrEn = wr; modeWrData = 3'(wd); irqTake = irq;
    retiStrobe = reti; ioWake = wake;
    off = (em == 6);
    tk = irq && !off && !(em == 0 && ei);
    rt = !tk && reti && em == 0 && ei;
    wk = off && wake;
    if (wk) begin em = 0; es = 0; ei = 1'b0; end
    else if (tk) begin es = em; em = 0; ei = 1'b1; end
    else if (rt) begin em = es; ei = 1'b0; end
    else if (wr && em == 0) em = (wd == 7) ? 0 : wd;
    @(negedge clk);
    modeWrEn = 1'b0; irqTake = 1'b0; retiStrobe = 1'b0; ioWake = 1'b0;
    check({req, " mode"}, int'(curMode), em);
    check({req, " resetReq"}, int'(resetReq), int'(wk));
    @(negedge clk);
    check({req, " enables"}, int'({cpuRun, mclkEn, smclkEn, aclkEn, dcoEn,
          dcGenEn, fllEn, xtalEn, regulatorEn, retainEn}), int'(expEn(em)));
    check({req, " resetReq low"}, int'(resetReq), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    // R1: reset state
    check("R1 mode", int'(curMode), 0);
    check("R1 enables", int'({cpuRun, mclkEn, smclkEn, aclkEn, dcoEn, dcGenEn,
          fllEn, xtalEn, regulatorEn, retainEn}), 10'h3ff);
    check("R1 resetReq", int'(resetReq), 0);

    // Sweep every start mode: R2 write/ignore, R3 ladder, R4 irq, R5 return, R6 off
    for (int m = 0; m < 8; m++) begin
      doReset();
      step(1, m, 0, 0, 0, "R2 R3 write");
      step(1, 3, 0, 0, 0, "R2 write while asleep");
      step(0, 0, 0, 0, 1, "R6 wake");
      step(0, 0, 1, 0, 0, "R4 irq");
      step(0, 0, 0, 1, 0, "R5 reti");
      step(0, 0, 0, 0, 1, "R6 wake again");
    end

    // R6: off mode ignores irq, return and writes; wake leaves
    doReset();
    step(1, 6, 0, 0, 0, "R9 enter off");
    step(0, 0, 1, 1, 0, "R6 irq+reti in off");
    step(1, 2, 0, 0, 0, "R6 write in off");
    step(0, 0, 0, 0, 1, "R6 wake from off");

    // R5: return outside handler ignored
    doReset();
    step(0, 0, 0, 1, 0, "R5 reti outside handler");

    // R8: second irq inside handler keeps saved mode
    doReset();
    step(1, 3, 0, 0, 0, "R8 sleep");
    step(0, 0, 1, 0, 0, "R8 first irq");
    step(0, 0, 1, 0, 0, "R8 nested irq");
    step(0, 0, 0, 1, 0, "R8 reti");

    // R7: priority in one cycle
    doReset();
    step(1, 2, 0, 0, 0, "R7 sleep");
    step(0, 0, 1, 0, 0, "R7 irq");
    step(1, 4, 1, 1, 0, "R7 reti beats write");
    doReset();
    step(1, 4, 1, 0, 0, "R7 irq beats write");
    step(0, 0, 0, 1, 0, "R7 reti back");

    // R6: ioWake outside off has no effect
    doReset();
    step(1, 4, 0, 0, 0, "R6 sleep3");
    step(0, 0, 0, 0, 1, "R6 wake ignored");

    // R4: irq in running mode outside handler enters handler
    doReset();
    step(0, 0, 1, 0, 0, "R4 irq while running");
    step(0, 0, 0, 1, 0, "R4 return to running");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule